// File: doc/BRIEF.md
# SCSI DMA Channel Control and Status Register Bank

This block is the register front end of a SCSI DMA channel. It has four 32-bit registers in a 16-byte window, and bits [3:2] of the byte address pick one. Writes take effect at the clock edge. Reads are combinational from the stored value.

Register 0 is the control/status word. A control write is not stored as given. The top nibble is always replaced by the version code 0xA. Bit 6 clears itself, or is set when the written value is exactly zero. Bit 7 resets the attached SCSI controller. Bit 4 enables the interrupt, and writing it as zero pulses an interrupt-deassert output. Bit 0 is the interrupt-pending flag, set by event pulses from the controller.

Register 1 holds the transfer address, which is only stored. Any write to it replaces the control word with a "loaded" pattern. Registers 2 and 3 are plain storage.

Top module: `scsi_dma_csr`

## Requirements
- R1: The register index is byte address bits [3:2]. Address bits [1:0] are ignored. Registers 2 and 3 store and return the written 32-bit value.
- R2: An `irq_event` pulse sets bit 0 of register 0 at the next clock edge.
- R3: A write to register 0 with bit 4 clear raises `irq_deassert` for exactly the one cycle after the write. A write to register 0 with bit 4 set leaves it low.
- R4: A write to register 0 with bit 7 set raises `ctl_reset` for exactly the one cycle after the write, and clears registers 1, 2 and 3. Register 0 still takes the written value after the bit 31..28 rewrite of R7, and bit 6 is kept as written.
- R5: A write to register 0 with bit 7 clear and bit 6 set stores bit 6 as 0.
- R6: A write of exactly 0x0000_0000 to register 0 stores 0xA000_0040.
- R7: Every value stored by a register 0 write has bits 31..28 equal to 0xA, and bits 27..0 taken from the rewritten write value.
- R8: A write to register 1 stores the data in register 1, and sets register 0 to 0x0400_0000.
- R9: Reads have no side effects. Two reads in a row return the same value, and no state changes.
- R10: When `irq_event` and a write to register 0 or register 1 fall in the same cycle, bit 0 of register 0 ends up set, on top of the value the write produces.
- R11: After reset all four registers read 0, and both pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 4 | Byte address inside the 16-byte window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read of the addressed register |
| irq_event | input | 1 | Interrupt event pulse from the SCSI controller |
| irq_deassert | output | 1 | One-cycle pulse telling the interrupt line to drop |
| ctl_reset | output | 1 | One-cycle reset pulse for the SCSI controller |

## Verification
An interrupt event from the controller can land in the same cycle as a software write. That write may rewrite the control word or replace it with the loaded pattern. The bench raises `irq_event` in the same cycle as a register 0 write and as a register 1 write. It then reads register 0 back and expects the rewritten write value with bit 0 forced to one. A reset write paired with an event is checked the same way: register 0 must keep bit 0 while the other registers are cleared.

// File: rtl/scsi_dma_csr_pkg.sv
package scsi_dma_csr_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned REG_NUM = 4;
    localparam int unsigned IDX_W   = $clog2(REG_NUM);
    localparam int unsigned ADDR_W  = IDX_W + 2;

    localparam int unsigned CTL_IDX  = 0;
    localparam int unsigned ADR_IDX  = 1;

    localparam logic [3:0]        VERSION_NIB = 4'hA;
    localparam logic [DATA_W-1:0] LOADED_WORD = 32'h0400_0000;

    localparam int unsigned BIT_PEND  = 0;
    localparam int unsigned BIT_IEN   = 4;
    localparam int unsigned BIT_TOG   = 6;
    localparam int unsigned BIT_RESET = 7;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [REG_NUM-1:0][DATA_W-1:0] bank_t;

    typedef struct packed {
        word_t value;
        logic  reset_req;
        logic  deassert_req;
    } ctl_rewrite_t;

    typedef struct packed {
        bank_t regs;
        logic  rst_pulse;
        logic  deassert_pulse;
    } csr_state_t;

endpackage

// File: rtl/scsi_dma_csr_decode.sv
module scsi_dma_csr_decode
    import scsi_dma_csr_pkg::*;
(
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    idx,
    output logic [REG_NUM-1:0]  wr_sel
);
    for (genvar i = 0; i < REG_NUM; i++) begin : g_sel
        assign wr_sel[i] = wr_en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/scsi_dma_csr_rewrite.sv
module scsi_dma_csr_rewrite
    import scsi_dma_csr_pkg::*;
(
    input  word_t        raw,
    output ctl_rewrite_t res
);
    word_t v;

    always_comb begin
        v = raw;
        if (raw[BIT_RESET]) begin
            v = raw;
        end else if (raw[BIT_TOG]) begin
            v[BIT_TOG] = 1'b0;
        end else if (raw == '0) begin
            v[BIT_TOG] = 1'b1;
        end
        res.value        = {VERSION_NIB, v[DATA_W-5:0]};
        res.reset_req    = raw[BIT_RESET];
        res.deassert_req = !raw[BIT_IEN];
    end
endmodule

// File: rtl/scsi_dma_csr_regs.sv
module scsi_dma_csr_regs
    import scsi_dma_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_NUM-1:0] wr_sel,
    input  word_t              wr_data,
    input  ctl_rewrite_t       ctl,
    input  logic               irq_event,
    output bank_t              regs_q,
    output logic               rst_pulse_q,
    output logic               deassert_pulse_q
);
    csr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.rst_pulse      = 1'b0;
        st_d.deassert_pulse = 1'b0;

        for (int i = ADR_IDX + 1; i < REG_NUM; i++) begin
            if (wr_sel[i]) begin
                st_d.regs[i] = wr_data;
            end
        end

        if (wr_sel[CTL_IDX]) begin
            if (ctl.reset_req) begin
                for (int i = 1; i < REG_NUM; i++) begin
                    st_d.regs[i] = '0;
                end
            end
            st_d.regs[CTL_IDX]  = ctl.value;
            st_d.rst_pulse      = ctl.reset_req;
            st_d.deassert_pulse = ctl.deassert_req;
        end

        if (wr_sel[ADR_IDX]) begin
            st_d.regs[ADR_IDX] = wr_data;
            st_d.regs[CTL_IDX] = LOADED_WORD;
        end

        if (irq_event) begin
            st_d.regs[CTL_IDX][BIT_PEND] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_q           = st_q.regs;
    assign rst_pulse_q      = st_q.rst_pulse;
    assign deassert_pulse_q = st_q.deassert_pulse;
endmodule

// File: rtl/scsi_dma_csr.sv
module scsi_dma_csr
    import scsi_dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_event,
    output logic              irq_deassert,
    output logic              ctl_reset
);
    logic [IDX_W-1:0]   idx;
    logic [REG_NUM-1:0] wr_sel;
    ctl_rewrite_t       ctl;
    bank_t              regs_q;
    logic               unused_lsb;

    assign idx        = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    scsi_dma_csr_decode u_decode (
        .wr_en  (wr_en),
        .idx    (idx),
        .wr_sel (wr_sel)
    );

    scsi_dma_csr_rewrite u_rewrite (
        .raw (wr_data),
        .res (ctl)
    );

    scsi_dma_csr_regs u_regs (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_sel           (wr_sel),
        .wr_data          (wr_data),
        .ctl              (ctl),
        .irq_event        (irq_event),
        .regs_q           (regs_q),
        .rst_pulse_q      (ctl_reset),
        .deassert_pulse_q (irq_deassert)
    );

    assign rd_data = regs_q[idx];
endmodule

// File: rtl/scsi_dma_csr_chk.sv
module scsi_dma_csr_chk
    import scsi_dma_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_event,
    input bank_t             regs,
    input logic              irq_deassert,
    input logic              ctl_reset
);
    logic ctl_wr, adr_wr;
    assign ctl_wr = wr_en && (addr[ADDR_W-1:2] == IDX_W'(CTL_IDX));
    assign adr_wr = wr_en && (addr[ADDR_W-1:2] == IDX_W'(ADR_IDX));

    assert_event_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event |=> regs[CTL_IDX][BIT_PEND]);

    assert_deassert_on_ien_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_data[BIT_IEN]) |=> irq_deassert);

    assert_no_deassert_otherwise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && !wr_data[BIT_IEN]) |=> !irq_deassert);

    assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[BIT_RESET]) |=> (ctl_reset && regs[ADR_IDX] == '0));

    assert_no_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && wr_data[BIT_RESET]) |=> !ctl_reset);

    assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data == '0 && !irq_event) |=> (regs[CTL_IDX] == 32'hA000_0040));

    assert_version_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (regs[CTL_IDX][DATA_W-1:DATA_W-4] == VERSION_NIB));

    assert_loaded_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_wr && !irq_event) |=> (regs[CTL_IDX] == LOADED_WORD
                                    && regs[ADR_IDX] == $past(wr_data)));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !irq_event) |=> $stable(regs));
endmodule

bind scsi_dma_csr scsi_dma_csr_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .irq_event    (irq_event),
    .regs         (regs_q),
    .irq_deassert (irq_deassert),
    .ctl_reset    (ctl_reset)
);

// File: tb/scsi_dma_csr_bench.sv
module scsi_dma_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_event = 1'b0;
    logic        irq_deassert;
    logic        ctl_reset;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    scsi_dma_csr u_scsi_dma_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .irq_event    (irq_event),
        .irq_deassert (irq_deassert),
        .ctl_reset    (ctl_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Write in one cycle; on return the registered pulses of that write are visible.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic ev);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d; irq_event = ev;
        @(negedge clk);
        wr_en = 1'b0; irq_event = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic pulse_event();
        @(negedge clk);
        irq_event = 1'b1;
        @(negedge clk);
        irq_event = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            rd(4'(i * 4), v);
            chk("R11 reset reg", v, 32'h0);
        end
        chk("R11 reset pulses", {30'b0, irq_deassert, ctl_reset}, 32'h0);
    endtask

    task automatic t_plain_storage();
        logic [31:0] v;
        wr(4'h8, 32'h1357_9BDF, 1'b0);
        wr(4'hF, 32'hCAFE_F00D, 1'b0);
        rd(4'h8, v); chk("R1 reg2 storage", v, 32'h1357_9BDF);
        rd(4'hC, v); chk("R1 reg3 via byte offset 3", v, 32'hCAFE_F00D);
        rd(4'hA, v); chk("R1 lsb ignored on read", v, 32'h1357_9BDF);
    endtask

    task automatic t_event();
        logic [31:0] v;
        wr(4'h0, 32'h0000_0010, 1'b0);
        pulse_event();
        rd(4'h0, v); chk("R2 event sets pending", v, 32'hA000_0011);
    endtask

    task automatic t_ien();
        wr(4'h0, 32'h0000_0010, 1'b0);
        chk("R3 ien set no deassert", {31'b0, irq_deassert}, 32'h0);
        wr(4'h0, 32'h0000_0001, 1'b0);
        chk("R3 ien clear deassert", {31'b0, irq_deassert}, 32'h1);
        @(negedge clk);
        chk("R3 deassert one cycle", {31'b0, irq_deassert}, 32'h0);
    endtask

    task automatic t_reset_write();
        logic [31:0] v;
        wr(4'h4, 32'h1111_2222, 1'b0);
        wr(4'h8, 32'h3333_4444, 1'b0);
        wr(4'hC, 32'h5555_6666, 1'b0);
        wr(4'h0, 32'h0000_00D0, 1'b0);
        chk("R4 ctl_reset pulse", {31'b0, ctl_reset}, 32'h1);
        chk("R4 no deassert with ien set", {31'b0, irq_deassert}, 32'h0);
        @(negedge clk);
        chk("R4 ctl_reset one cycle", {31'b0, ctl_reset}, 32'h0);
        rd(4'h0, v); chk("R4 reg0 keeps bit6", v, 32'hA000_00D0);
        rd(4'h4, v); chk("R4 reg1 cleared", v, 32'h0);
        rd(4'h8, v); chk("R4 reg2 cleared", v, 32'h0);
        rd(4'hC, v); chk("R4 reg3 cleared", v, 32'h0);
    endtask

    task automatic t_bit6_and_zero();
        logic [31:0] v;
        wr(4'h0, 32'h0000_0050, 1'b0);
        rd(4'h0, v); chk("R5 bit6 self clears", v, 32'hA000_0010);
        wr(4'h0, 32'h0000_0000, 1'b0);
        rd(4'h0, v); chk("R6 zero write sets bit6", v, 32'hA000_0040);
    endtask

    task automatic t_version();
        logic [31:0] v;
        wr(4'h0, 32'h5123_4531, 1'b0);
        rd(4'h0, v); chk("R7 version nibble", v, 32'hA123_4531);
        wr(4'h0, 32'hF000_0000, 1'b0);
        rd(4'h0, v); chk("R7 top nibble only", v, 32'hA000_0000);
    endtask

    task automatic t_addr_write();
        logic [31:0] v;
        wr(4'h4, 32'hDEAD_BEE0, 1'b0);
        rd(4'h0, v); chk("R8 loaded word", v, 32'h0400_0000);
        rd(4'h4, v); chk("R8 address stored", v, 32'hDEAD_BEE0);
    endtask

    task automatic t_read_no_side();
        logic [31:0] a, b;
        rd(4'h0, a);
        @(negedge clk);
        rd(4'h0, b);
        chk("R9 reread reg0", b, a);
        rd(4'h4, b); chk("R9 reg1 unchanged", b, 32'hDEAD_BEE0);
    endtask

    task automatic t_collisions();
        logic [31:0] v;
        wr(4'h0, 32'h0000_0050, 1'b1);
        rd(4'h0, v); chk("R10 event with ctl write", v, 32'hA000_0011);
        wr(4'h4, 32'h0000_1000, 1'b1);
        rd(4'h0, v); chk("R10 event with addr write", v, 32'h0400_0001);
        wr(4'h0, 32'h0000_0090, 1'b1);
        rd(4'h0, v); chk("R10 event with reset write", v, 32'hA000_0091);
        rd(4'h4, v); chk("R10 reset clears reg1", v, 32'h0);
    endtask

    initial begin
        t_reset_state();
        t_plain_storage();
        t_event();
        t_ien();
        t_reset_write();
        t_bit6_and_zero();
        t_version();
        t_addr_write();
        t_read_no_side();
        t_collisions();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule